// File: doc/BRIEF.md
# Byte Store Write Controller

This block manages a small on-chip array of data bytes through a register bus. Software loads a location into an address register and a byte into a data register. It then starts either a read, which copies the addressed byte into the data register at once, or a write, which takes a fixed number of clock cycles. A write erases the location to all ones in its first half and programs the new byte at its end. A write cannot begin by accident. Write permission must already be enabled, and a two-byte key must be written to a key register on the bus accesses just before the start bit is set.

Completion raises an interrupt flag that stays set until software clears it. A separate synchronous warm reset aborts any write in progress. When that happens it leaves a sticky error bit behind, and it keeps the address and data registers so software can retry. Only the first `DEPTH` locations exist. An address at or beyond that limit never aliases onto a lower location.

Top module: `nvbyte_wr_ctrl`

## Requirements
- R1: After power-on reset (`por_ni` low), ADDR (offset 0), DATA (offset 1), CTRL (offset 2), KEY (offset 3) and FLAG (offset 4) all read 0x00, and `busy_o` and `irq_o` are low.
- R2: A bus write to CTRL with bit 0 (read start) set loads DATA with the addressed byte on that clock edge. CTRL bit 0 always reads 0.
- R3: DATA keeps its value until another read start or a direct bus write to DATA. Writing ADDR does not change it.
- R4: CTRL bit 2 (write enable) holds the value last written to it. A write starts only if it was already 1 before the bus write that sets CTRL bit 1 (write start). Writing 0x06 with enable previously 0 starts nothing.
- R5: A write starts only if the two bus accesses just before the start were KEY writes of 0x55 and then 0xAA. Any other bus access (`bus_sel_i` high, read or write) in between cancels the unlock.
- R6: `busy_o` and CTRL bit 1 stay high for exactly `WR_CYCLES` cycles after the start edge. On the last edge the byte latched at start is stored and `irq_o` (FLAG bit 0) rises.
- R7: A write sets the addressed location to 0xFF once `WR_CYCLES/2` cycles have passed since the start, and only then programs the new byte.
- R8: `irq_o` stays high until a bus write to FLAG with bit 0 set (write-one-to-clear) or a warm reset.
- R9: Clearing write enable while a write is running does not abort it.
- R10: A warm reset (`warm_rst_i` high at an edge) during a write stops it, sets CTRL bit 3 (error), and keeps ADDR and DATA. The error bit stays set until CTRL is written with bit 3 set or power-on reset occurs.
- R11: For ADDR ≥ `DEPTH`, a read loads 0x00 and a write changes no location. The write is still timed and still signals completion.
- R12: Setting write start while a write is running is ignored. The running write keeps its address, data and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Asynchronous power-on reset, active low, clears all registers |
| warm_rst_i | input | 1 | Synchronous warm reset, aborts a running write |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Bus access is a write |
| bus_addr_i | input | 3 | Register offset |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Register selected by `bus_addr_i`, combinational |
| busy_o | output | 1 | Write in progress |
| irq_o | output | 1 | Write completion flag |

## Verification
The bench builds the block with `DEPTH` = 128 and `WR_CYCLES` = 16. This keeps each write short enough to watch cycle by cycle. It lets the bench sample the erase midpoint at cycle 9 and the end of busy at cycle 16. An address of 0x80 is one past the last valid location, so the no-wrap rule can be tested against location 0. The timed write length is the only parameter that changes run time. The bench therefore tests the full sequence many times: key cancels, aborts, restarts while busy and out-of-range writes.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] RG_ADDR = 3'd0;
    localparam logic [REG_AW-1:0] RG_DATA = 3'd1;
    localparam logic [REG_AW-1:0] RG_CTRL = 3'd2;
    localparam logic [REG_AW-1:0] RG_KEY  = 3'd3;
    localparam logic [REG_AW-1:0] RG_FLAG = 3'd4;

    localparam int CB_RD  = 0;
    localparam int CB_GO  = 1;
    localparam int CB_EN  = 2;
    localparam int CB_ERR = 3;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;
    localparam logic [7:0] ERASED     = 8'hFF;

    typedef enum logic [1:0] {
        UL_IDLE,
        UL_HALF,
        UL_ARMED
    } unlock_e;
endpackage

// File: rtl/nvb_unlock.sv
module nvb_unlock
    import nvb_pkg::*;
(
    input  logic              clk_i,
    input  logic              por_ni,
    input  logic              clr_i,
    input  logic              acc_i,
    input  logic              we_i,
    input  logic [REG_AW-1:0] sel_i,
    input  logic [7:0]        wdata_i,
    output logic              armed_o
);
    unlock_e st_d, st_q;
    logic key_wr;

    always_comb begin
        key_wr = acc_i && we_i && (sel_i == RG_KEY);
        st_d   = st_q;
        if (clr_i) begin
            st_d = UL_IDLE;
        end else if (acc_i) begin
            if (key_wr && wdata_i == KEY_FIRST) begin
                st_d = UL_HALF;
            end else if (key_wr && wdata_i == KEY_SECOND && st_q == UL_HALF) begin
                st_d = UL_ARMED;
            end else begin
                st_d = UL_IDLE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) st_q <= UL_IDLE;
        else         st_q <= st_d;
    end

    assign armed_o = (st_q == UL_ARMED);
endmodule

// File: rtl/nvb_timer.sv
module nvb_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk_i,
    input  logic por_ni,
    input  logic start_i,
    input  logic abort_i,
    output logic run_o,
    output logic erase_o,
    output logic done_o
);
    localparam int CW   = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam int HALF = CYCLES / 2;

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (abort_i) begin
            t_d = '0;
        end else if (start_i && !t_q.run) begin
            t_d.run = 1'b1;
            t_d.cnt = CW'(CYCLES - 1);
        end else if (t_q.run) begin
            if (t_q.cnt == '0) t_d.run = 1'b0;
            else               t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) t_q <= '0;
        else         t_q <= t_d;
    end

    assign run_o   = t_q.run;
    assign erase_o = t_q.run && (t_q.cnt == CW'(HALF));
    assign done_o  = t_q.run && (t_q.cnt == '0);
endmodule

// File: rtl/nvb_store.sv
module nvb_store #(
    parameter int DEPTH = 128
) (
    input  logic                     clk_i,
    input  logic                     we_i,
    input  logic [$clog2(DEPTH)-1:0] waddr_i,
    input  logic [7:0]               wdata_i,
    input  logic [$clog2(DEPTH)-1:0] raddr_i,
    output logic [7:0]               rdata_o
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) cells[waddr_i] <= wdata_i;
    end

    assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/nvbyte_wr_ctrl.sv
module nvbyte_wr_ctrl
    import nvb_pkg::*;
#(
    parameter int DEPTH     = 128,
    parameter int WR_CYCLES = 64
) (
    input  logic              clk_i,
    input  logic              por_ni,
    input  logic              warm_rst_i,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [REG_AW-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    output logic              busy_o,
    output logic              irq_o
);
    localparam int         IW    = $clog2(DEPTH);
    localparam logic [8:0] LIMIT = 9'(DEPTH);

    typedef struct packed {
        logic [7:0]    addr;
        logic [7:0]    data;
        logic          wr_en;
        logic          err;
        logic          irq;
        logic [IW-1:0] waddr;
        logic [7:0]    wdata;
        logic          wvalid;
    } regs_t;

    regs_t regs_d, regs_q;

    logic       acc, wr, start, rd_go, armed, in_range;
    logic       t_run, t_erase, t_done;
    logic       st_we;
    logic [7:0] st_wdata, st_rdata;

    nvb_unlock u_unlock (
        .clk_i   (clk_i),
        .por_ni  (por_ni),
        .clr_i   (warm_rst_i),
        .acc_i   (acc),
        .we_i    (bus_we_i),
        .sel_i   (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .armed_o (armed)
    );

    nvb_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk_i   (clk_i),
        .por_ni  (por_ni),
        .start_i (start),
        .abort_i (warm_rst_i),
        .run_o   (t_run),
        .erase_o (t_erase),
        .done_o  (t_done)
    );

    nvb_store #(.DEPTH(DEPTH)) u_store (
        .clk_i   (clk_i),
        .we_i    (st_we),
        .waddr_i (regs_q.waddr),
        .wdata_i (st_wdata),
        .raddr_i (regs_q.addr[IW-1:0]),
        .rdata_o (st_rdata)
    );

    always_comb begin
        acc      = bus_sel_i && !warm_rst_i;
        wr       = acc && bus_we_i;
        in_range = {1'b0, regs_q.addr} < LIMIT;
        rd_go    = wr && (bus_addr_i == RG_CTRL) && bus_wdata_i[CB_RD];
        start    = wr && (bus_addr_i == RG_CTRL) && bus_wdata_i[CB_GO]
                   && regs_q.wr_en && armed && !t_run;

        regs_d = regs_q;
        if (wr && bus_addr_i == RG_ADDR) regs_d.addr = bus_wdata_i;
        if (wr && bus_addr_i == RG_DATA) regs_d.data = bus_wdata_i;
        if (rd_go) regs_d.data = in_range ? st_rdata : 8'h00;
        if (wr && bus_addr_i == RG_CTRL) begin
            regs_d.wr_en = bus_wdata_i[CB_EN];
            if (bus_wdata_i[CB_ERR]) regs_d.err = 1'b0;
        end
        if (wr && bus_addr_i == RG_FLAG && bus_wdata_i[0]) regs_d.irq = 1'b0;
        if (start) begin
            regs_d.waddr  = regs_q.addr[IW-1:0];
            regs_d.wdata  = regs_q.data;
            regs_d.wvalid = in_range;
        end
        if (t_done && !warm_rst_i) regs_d.irq = 1'b1;
        if (warm_rst_i) begin
            regs_d.wr_en = 1'b0;
            regs_d.irq   = 1'b0;
            if (t_run) regs_d.err = 1'b1;
        end

        st_we    = !warm_rst_i && regs_q.wvalid && (t_erase || t_done);
        st_wdata = t_done ? regs_q.wdata : ERASED;

        case (bus_addr_i)
            RG_ADDR: bus_rdata_o = regs_q.addr;
            RG_DATA: bus_rdata_o = regs_q.data;
            RG_CTRL: bus_rdata_o = {4'b0, regs_q.err, regs_q.wr_en, t_run, 1'b0};
            RG_FLAG: bus_rdata_o = {7'b0, regs_q.irq};
            default: bus_rdata_o = 8'h00;
        endcase
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    assign busy_o = t_run;
    assign irq_o  = regs_q.irq;
endmodule

// File: rtl/nvb_chk.sv
module nvb_chk
    import nvb_pkg::*;
#(
    parameter int WR_CYCLES = 64
) (
    input logic              clk_i,
    input logic              por_ni,
    input logic              warm_rst_i,
    input logic              bus_sel_i,
    input logic              bus_we_i,
    input logic [REG_AW-1:0] bus_addr_i,
    input logic              w0_i,
    input logic              w3_i,
    input logic              busy_o,
    input logic              irq_o,
    input logic              armed,
    input logic              wr_en_q,
    input logic              err_q,
    input logic [7:0]        addr_q,
    input logic [7:0]        data_q
);
    logic [31:0] busy_len;
    logic        flag_clr, err_clr;

    assign flag_clr = bus_sel_i && bus_we_i && bus_addr_i == RG_FLAG && w0_i;
    assign err_clr  = bus_sel_i && bus_we_i && bus_addr_i == RG_CTRL && w3_i;

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni)     busy_len <= '0;
        else if (busy_o) busy_len <= busy_len + 1;
        else             busy_len <= '0;
    end

    AST_START_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!por_ni)
        $rose(busy_o) |-> $past(armed && wr_en_q)); // R5
    AST_BUSY_SPAN: assert property (@(posedge clk_i) disable iff (!por_ni)
        ($fell(busy_o) && !$past(warm_rst_i)) |-> busy_len == WR_CYCLES); // R6
    AST_BUSY_BOUND: assert property (@(posedge clk_i) disable iff (!por_ni)
        busy_o |-> busy_len < WR_CYCLES); // R6
    AST_IRQ_ON_END: assert property (@(posedge clk_i) disable iff (!por_ni)
        ($fell(busy_o) && !$past(warm_rst_i)) |-> irq_o); // R6
    AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!por_ni)
        (irq_o && !warm_rst_i && !flag_clr) |=> irq_o); // R8
    AST_ERR_ON_ABORT: assert property (@(posedge clk_i) disable iff (!por_ni)
        (warm_rst_i && busy_o) |=> err_q); // R10
    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!por_ni)
        (err_q && !err_clr) |=> err_q); // R10
    AST_REGS_KEPT: assert property (@(posedge clk_i) disable iff (!por_ni)
        warm_rst_i |=> ($stable(addr_q) && $stable(data_q))); // R10
endmodule

bind nvbyte_wr_ctrl nvb_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk_i      (clk_i),
    .por_ni     (por_ni),
    .warm_rst_i (warm_rst_i),
    .bus_sel_i  (bus_sel_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .w0_i       (bus_wdata_i[0]),
    .w3_i       (bus_wdata_i[3]),
    .busy_o     (busy_o),
    .irq_o      (irq_o),
    .armed      (armed),
    .wr_en_q    (regs_q.wr_en),
    .err_q      (regs_q.err),
    .addr_q     (regs_q.addr),
    .data_q     (regs_q.data)
);

// File: tb/nvbyte_wr_ctrl_tb.sv
module nvbyte_wr_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 128;
    localparam int WR_CYCLES  = 16;

    localparam logic [2:0] A_ADDR = 3'd0, A_DATA = 3'd1, A_CTRL = 3'd2,
                           A_KEY = 3'd3, A_FLAG = 3'd4;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       warm = 1'b0;
    logic       sel = 1'b0, we = 1'b0;
    logic [2:0] badr = '0;
    logic [7:0] wdat = '0;
    logic [7:0] rdat;
    logic       busy, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvbyte_wr_ctrl #(.DEPTH(DEPTH), .WR_CYCLES(WR_CYCLES)) dut_i (
        .clk_i(clk), .por_ni(por_n), .warm_rst_i(warm),
        .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(badr),
        .bus_wdata_i(wdat), .bus_rdata_o(rdat), .busy_o(busy), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    // One bus write, captured by the next rising edge; returns at the following falling edge.
    task automatic bw(input logic [2:0] a, input logic [7:0] d);
        sel = 1'b1; we = 1'b1; badr = a; wdat = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    // Passive look at a register: read data is combinational, no access strobe.
    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        badr = a; #1; v = rdat;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic arm_and_go();
        bw(A_CTRL, 8'h04);
        bw(A_KEY, 8'h55);
        bw(A_KEY, 8'hAA);
        bw(A_CTRL, 8'h06);
    endtask

    task automatic full_write(input logic [7:0] a, input logic [7:0] d);
        bw(A_ADDR, a);
        bw(A_DATA, d);
        arm_and_go();
        cyc(WR_CYCLES);
        bw(A_FLAG, 8'h01);
    endtask

    task automatic mem_read(input logic [7:0] a, output logic [7:0] v);
        bw(A_ADDR, a);
        bw(A_CTRL, 8'h01);
        peek(A_DATA, v);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int r = 0; r < 5; r++) begin
            peek(3'(r), v);
            chk("R1 register after reset", v, 8'h00);
        end
        chk("R1 busy after reset", {7'b0, busy}, 8'h00);
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_write_read();
        logic [7:0] v;
        bw(A_ADDR, 8'h10);
        bw(A_DATA, 8'h5A);
        arm_and_go();
        chk("R6 busy at start", {7'b0, busy}, 8'h01);
        peek(A_CTRL, v);
        chk("R6 start bit set while running", v & 8'h02, 8'h02);
        cyc(WR_CYCLES - 1);
        chk("R6 busy on last cycle", {7'b0, busy}, 8'h01);
        chk("R6 no irq before end", {7'b0, irq}, 8'h00);
        cyc(1);
        chk("R6 busy cleared", {7'b0, busy}, 8'h00);
        chk("R6 irq raised", {7'b0, irq}, 8'h01);
        peek(A_CTRL, v);
        chk("R6 start bit self-cleared", v & 8'h02, 8'h00);
        cyc(3);
        chk("R8 irq held", {7'b0, irq}, 8'h01);
        bw(A_FLAG, 8'h00);
        chk("R8 writing zero keeps irq", {7'b0, irq}, 8'h01);
        bw(A_FLAG, 8'h01);
        chk("R8 irq cleared by one", {7'b0, irq}, 8'h00);
        bw(A_DATA, 8'h00);
        bw(A_CTRL, 8'h01);
        peek(A_DATA, v);
        chk("R2 read loads data", v, 8'h5A);
        peek(A_CTRL, v);
        chk("R2 read bit reads zero", v & 8'h01, 8'h00);
        bw(A_ADDR, 8'h11);
        cyc(2);
        peek(A_DATA, v);
        chk("R3 data kept after address change", v, 8'h5A);
        bw(A_DATA, 8'hC3);
        peek(A_DATA, v);
        chk("R3 data overwritten by bus", v, 8'hC3);
    endtask

    task automatic t_enable_rule();
        logic [7:0] v;
        bw(A_CTRL, 8'h00);
        bw(A_ADDR, 8'h20);
        bw(A_DATA, 8'h99);
        bw(A_KEY, 8'h55);
        bw(A_KEY, 8'hAA);
        bw(A_CTRL, 8'h06);
        chk("R4 enable and start together do not start", {7'b0, busy}, 8'h00);
        peek(A_CTRL, v);
        chk("R4 enable bit now set", v & 8'h04, 8'h04);
    endtask

    task automatic t_unlock_cancel();
        bw(A_ADDR, 8'h21);
        bw(A_DATA, 8'h42);
        bw(A_CTRL, 8'h04);
        bw(A_KEY, 8'h55);
        bw(A_DATA, 8'h42);
        bw(A_KEY, 8'hAA);
        bw(A_CTRL, 8'h06);
        chk("R5 write between keys cancels", {7'b0, busy}, 8'h00);
        bw(A_CTRL, 8'h04);
        bw(A_KEY, 8'h55);
        bw(A_KEY, 8'hAA);
        sel = 1'b1; we = 1'b0; badr = A_FLAG;
        @(negedge clk);
        sel = 1'b0;
        bw(A_CTRL, 8'h06);
        chk("R5 read access before start cancels", {7'b0, busy}, 8'h00);
        bw(A_KEY, 8'hAA);
        bw(A_KEY, 8'h55);
        bw(A_CTRL, 8'h06);
        chk("R5 reversed key order rejected", {7'b0, busy}, 8'h00);
        bw(A_KEY, 8'h55);
        bw(A_KEY, 8'hAA);
        bw(A_CTRL, 8'h06);
        chk("R5 correct key starts", {7'b0, busy}, 8'h01);
        cyc(WR_CYCLES);
        bw(A_FLAG, 8'h01);
    endtask

    task automatic t_erase_and_enable_clear();
        logic [7:0] v;
        full_write(8'h30, 8'h3C);
        bw(A_ADDR, 8'h30);
        bw(A_DATA, 8'h81);
        arm_and_go();
        bw(A_CTRL, 8'h01);
        peek(A_DATA, v);
        chk("R7 old value before erase", v, 8'h3C);
        cyc(7);
        bw(A_CTRL, 8'h01);
        peek(A_DATA, v);
        chk("R7 erased value after half", v, 8'hFF);
        chk("R9 still busy after enable cleared", {7'b0, busy}, 8'h01);
        cyc(7);
        chk("R9 write completes", {7'b0, irq}, 8'h01);
        bw(A_FLAG, 8'h01);
        mem_read(8'h30, v);
        chk("R9 new value stored", v, 8'h81);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        full_write(8'h40, 8'h6D);
        bw(A_ADDR, 8'h40);
        bw(A_DATA, 8'hE7);
        arm_and_go();
        cyc(2);
        warm = 1'b1;
        @(negedge clk);
        warm = 1'b0;
        chk("R10 busy dropped by warm reset", {7'b0, busy}, 8'h00);
        peek(A_CTRL, v);
        chk("R10 error bit set", v & 8'h08, 8'h08);
        peek(A_ADDR, v);
        chk("R10 address kept", v, 8'h40);
        peek(A_DATA, v);
        chk("R10 data kept", v, 8'hE7);
        cyc(WR_CYCLES + 2);
        chk("R10 no completion after abort", {7'b0, irq}, 8'h00);
        bw(A_CTRL, 8'h00);
        peek(A_CTRL, v);
        chk("R10 error sticky on zero write", v & 8'h08, 8'h08);
        bw(A_CTRL, 8'h08);
        peek(A_CTRL, v);
        chk("R10 error cleared by one", v & 8'h08, 8'h00);
        mem_read(8'h40, v);
        chk("R10 early abort leaves cell", v, 8'h6D);
    endtask

    task automatic t_range();
        logic [7:0] v;
        full_write(8'h00, 8'hA5);
        bw(A_ADDR, 8'h80);
        bw(A_DATA, 8'h3C);
        arm_and_go();
        cyc(WR_CYCLES);
        chk("R11 out of range still completes", {7'b0, irq}, 8'h01);
        bw(A_FLAG, 8'h01);
        mem_read(8'h00, v);
        chk("R11 location 0 not overwritten", v, 8'hA5);
        mem_read(8'h80, v);
        chk("R11 out of range reads zero", v, 8'h00);
    endtask

    task automatic t_restart_busy();
        logic [7:0] v;
        full_write(8'h06, 8'h77);
        bw(A_ADDR, 8'h05);
        bw(A_DATA, 8'h11);
        arm_and_go();
        bw(A_ADDR, 8'h06);
        bw(A_DATA, 8'h22);
        bw(A_KEY, 8'h55);
        bw(A_KEY, 8'hAA);
        bw(A_CTRL, 8'h06);
        cyc(WR_CYCLES - 6);
        chk("R12 first write ends on schedule", {7'b0, busy}, 8'h01);
        cyc(1);
        chk("R12 busy cleared once", {7'b0, busy}, 8'h00);
        cyc(WR_CYCLES + 2);
        chk("R12 no second write", {7'b0, busy}, 8'h00);
        bw(A_FLAG, 8'h01);
        mem_read(8'h05, v);
        chk("R12 first write stored", v, 8'h11);
        mem_read(8'h06, v);
        chk("R12 ignored start left cell", v, 8'h77);
    endtask

    initial begin
        cyc(3);
        por_n = 1'b1;
        cyc(1);
        t_reset();
        t_write_read();
        t_enable_rule();
        t_unlock_cancel();
        t_erase_and_enable_clear();
        t_abort();
        t_range();
        t_restart_busy();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule